// File: doc/BRIEF.md
# Condition Register Field Lookup Logic Unit

This unit evaluates Boolean functions in place on a 32-bit condition register that is split into eight 4-bit fields. Every result bit comes from a truth-table lookup. The truth table is either an 8-entry immediate, for three-input functions, or the contents of another condition field, for two-input functions. One of the inputs to each lookup is always the current value of the bit being overwritten.

Four operations are provided:

- **Whole-field ternary.** Operates on all four bits of a field, under a per-bit write mask.
- **Whole-field binary.** Operates on all four bits of a field, under a per-bit write mask. Its table is taken from a field.
- **Single-bit ternary.**
- **Single-bit binary.** Its table is taken from a field.

The surrounding pipeline presents the current register on `cr_in` together with a one-cycle `op_valid` request. One cycle later the unit returns the updated register on `cr_out`. A whole-field binary request with an all-zero mask is refused: it raises `illegal` and returns the register unchanged. Decoding the instruction and taking the trap are the job of the surrounding logic.

Top module: `cr_lut_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `cr_out` is 0, `res_valid` is 0 and `illegal` is 0.
- R2: A request accepted with `op_valid`=1 at a clock edge produces `res_valid`=1 and the result on `cr_out` from that edge until the next one. Without a request, `res_valid` is 0 and `cr_out` holds its value.
- R3: Condition bits are numbered n=0..31 from the MSB, so bit n is `cr_in[31-n]`. Field F (0..7) is bits 4F..4F+3, and its bit i is bit 4F+i. Field operations use the low 3 bits of `dst_sel`, `srca_sel` and `srcb_sel` as field numbers.
- R4: For whole-field ternary (`op_sel`=0), result bit i is `imm_tbl[7-idx]`. Here idx = 4·D[i] + 2·A[i] + B[i], where D is the destination field, A is field `srca_sel` and B is field `srcb_sel`.
- R5: In a field operation, field bit i is written only when `wr_mask[3-i]` is 1. Otherwise it keeps its old value. Every bit outside the destination field is unchanged.
- R6: For whole-field binary (`op_sel`=1), result bit i is bit idx of field B, where idx = 2·D[i] + A[i]. Index 0 selects the field's leftmost bit.
- R7: A whole-field binary request with `wr_mask`=0 raises `illegal` and returns `cr_in` unchanged. A whole-field ternary request with `wr_mask`=0 returns `cr_in` unchanged and does not raise `illegal`.
- R8: For single-bit ternary (`op_sel`=2), bit `dst_sel` becomes `imm_tbl[7-idx]`, where idx = 4·bit[`dst_sel`] + 2·bit[`srca_sel`] + bit[`srcb_sel`].
- R9: For single-bit binary (`op_sel`=3), bit `dst_sel` becomes bit idx of field `srcb_sel[2:0]`, where idx = 2·bit[`dst_sel`] + bit[`srca_sel`]. `wr_mask` is ignored and `illegal` is never raised.
- R10: A single-bit operation changes no bit of the register other than bit `dst_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe, one cycle per operation |
| op_sel | input | 2 | 0 field ternary, 1 field binary, 2 bit ternary, 3 bit binary |
| cr_in | input | 32 | Current condition register |
| dst_sel | input | 5 | Destination bit, or field in its low 3 bits |
| srca_sel | input | 5 | First source bit, or field |
| srcb_sel | input | 5 | Second source bit, or field / table field |
| imm_tbl | input | 8 | Immediate 3-input truth table |
| wr_mask | input | 4 | Per-bit write mask for field operations, MSB = field bit 0 |
| res_valid | output | 1 | Result valid |
| cr_out | output | 32 | Updated condition register |
| illegal | output | 1 | Refused request (field binary with empty mask) |

## Verification
The assertions assume that `cr_in` and the operand fields are stable and meaningful only in the cycle `op_valid` is high, since they compare `cr_out` against the `cr_in` of the previous cycle. The bench drives every request for exactly one cycle at the falling edge, so each `$past` reference sees the request that produced the result. A random sweep covers every selector value and every mask pattern, including the empty mask and operations whose destination equals a source.

// File: rtl/cr_lut_pkg.sv
package cr_lut_pkg;
  localparam int CR_W   = 32;
  localparam int FLD_W  = 4;
  localparam int NFLD   = CR_W / FLD_W;
  localparam int BIT_IW = $clog2(CR_W);
  localparam int FLD_IW = $clog2(NFLD);
  localparam int TBL3_W = 8;

  typedef enum logic [1:0] {
    OP_FLD_TER = 2'd0,
    OP_FLD_BIN = 2'd1,
    OP_BIT_TER = 2'd2,
    OP_BIT_BIN = 2'd3
  } cr_op_e;

  // Field f of the register, field bit 0 in the returned MSB.
  function automatic logic [FLD_W-1:0] fld_get(logic [CR_W-1:0] cr, logic [FLD_IW-1:0] f);
    logic [CR_W-1:0] tmp;
    tmp = cr << (BIT_IW'(FLD_W) * BIT_IW'(f));
    return tmp[CR_W-1 -: FLD_W];
  endfunction

  // Bit n counted from the MSB.
  function automatic logic bit_get(logic [CR_W-1:0] cr, logic [BIT_IW-1:0] n);
    logic [CR_W-1:0] tmp;
    tmp = cr << n;
    return tmp[CR_W-1];
  endfunction

  // Table lookups, index 0 is the leftmost entry.
  function automatic logic pick8(logic [TBL3_W-1:0] t, logic [2:0] idx);
    return t[~idx];
  endfunction

  function automatic logic pick4(logic [FLD_W-1:0] t, logic [1:0] idx);
    return t[~idx];
  endfunction
endpackage

// File: rtl/cr_field_engine.sv
module cr_field_engine
  import cr_lut_pkg::*;
(
  input  logic [CR_W-1:0]   cr,
  input  logic              is_bin,
  input  logic [FLD_IW-1:0] dst,
  input  logic [FLD_IW-1:0] fa_sel,
  input  logic [FLD_IW-1:0] fb_sel,
  input  logic [TBL3_W-1:0] imm,
  input  logic [FLD_W-1:0]  mask,
  output logic [CR_W-1:0]   cr_new,
  output logic [CR_W-1:0]   wmask
);
  logic [FLD_W-1:0]  fd, fa, fb, nf;
  logic [BIT_IW-1:0] sh;
  logic [CR_W-1:0]   placed;

  assign fd = fld_get(cr, dst);
  assign fa = fld_get(cr, fa_sel);
  assign fb = fld_get(cr, fb_sel);

  for (genvar i = 0; i < FLD_W; i++) begin : g_bit
    localparam int P = FLD_W - 1 - i;
    logic t_ter, t_bin;
    assign t_ter = pick8(imm, {fd[P], fa[P], fb[P]});
    assign t_bin = pick4(fb, {fd[P], fa[P]});
    assign nf[P] = is_bin ? t_bin : t_ter;
  end

  assign sh     = BIT_IW'(FLD_W) * BIT_IW'(dst);
  assign wmask  = (CR_W'(mask) << (CR_W - FLD_W)) >> sh;
  assign placed = (CR_W'(nf) << (CR_W - FLD_W)) >> sh;
  assign cr_new = (cr & ~wmask) | (placed & wmask);
endmodule

// File: rtl/cr_bit_engine.sv
module cr_bit_engine
  import cr_lut_pkg::*;
(
  input  logic [CR_W-1:0]   cr,
  input  logic              is_bin,
  input  logic [BIT_IW-1:0] bt,
  input  logic [BIT_IW-1:0] ba,
  input  logic [BIT_IW-1:0] bb,
  input  logic [TBL3_W-1:0] imm,
  output logic [CR_W-1:0]   cr_new,
  output logic [CR_W-1:0]   wmask
);
  logic d, a, b, nb;
  logic [FLD_W-1:0] tbl;

  assign d   = bit_get(cr, bt);
  assign a   = bit_get(cr, ba);
  assign b   = bit_get(cr, bb);
  assign tbl = fld_get(cr, bb[FLD_IW-1:0]);
  assign nb  = is_bin ? pick4(tbl, {d, a}) : pick8(imm, {d, a, b});

  assign wmask  = {1'b1, {(CR_W-1){1'b0}}} >> bt;
  assign cr_new = (cr & ~wmask) | (nb ? wmask : '0);
endmodule

// File: rtl/cr_lut_unit.sv
module cr_lut_unit
  import cr_lut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_sel,
  input  logic [31:0] cr_in,
  input  logic [4:0]  dst_sel,
  input  logic [4:0]  srca_sel,
  input  logic [4:0]  srcb_sel,
  input  logic [7:0]  imm_tbl,
  input  logic [3:0]  wr_mask,
  output logic        res_valid,
  output logic [31:0] cr_out,
  output logic        illegal
);
  cr_op_e          op;
  logic [CR_W-1:0] fld_new, fld_wmask, bit_new, bit_wmask, nxt_cr;
  logic            is_fld_op, illegal_w;

  assign op        = cr_op_e'(op_sel);
  assign is_fld_op = (op == OP_FLD_TER) || (op == OP_FLD_BIN);
  assign illegal_w = (op == OP_FLD_BIN) && (wr_mask == '0);

  cr_field_engine u_fld (
    .cr(cr_in), .is_bin(op == OP_FLD_BIN),
    .dst(dst_sel[FLD_IW-1:0]), .fa_sel(srca_sel[FLD_IW-1:0]), .fb_sel(srcb_sel[FLD_IW-1:0]),
    .imm(imm_tbl), .mask(wr_mask), .cr_new(fld_new), .wmask(fld_wmask)
  );

  cr_bit_engine u_bit (
    .cr(cr_in), .is_bin(op == OP_BIT_BIN),
    .bt(dst_sel), .ba(srca_sel), .bb(srcb_sel),
    .imm(imm_tbl), .cr_new(bit_new), .wmask(bit_wmask)
  );

  always_comb begin
    if (illegal_w)      nxt_cr = cr_in;
    else if (is_fld_op) nxt_cr = fld_new;
    else                nxt_cr = bit_new;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      illegal   <= 1'b0;
      cr_out    <= '0;
    end else begin
      res_valid <= op_valid;
      illegal   <= op_valid && illegal_w;
      if (op_valid) cr_out <= nxt_cr;
    end
  end

  // R2: a result appears only for a request one cycle earlier
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(op_valid));
  // R2: the register output holds without a request
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> $stable(cr_out));
  // R7: a refused request returns the register unchanged
  a_r7_illegal_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && illegal) |-> (cr_out == $past(cr_in)));
  // R7: only a field binary request with an empty mask is refused
  a_r7_illegal_cause: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> ($past(op_sel) == 2'd1 && $past(wr_mask) == 4'd0));
  // R5: field operations touch only masked bits of the destination field
  a_r5_field_confined: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(op_sel[1])) |-> (((cr_out ^ $past(cr_in)) & ~$past(fld_wmask)) == '0));
  // R10: single-bit operations change at most one bit, and only the selected one
  a_r10_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(op_sel[1])) |-> ($countones(cr_out ^ $past(cr_in)) <= 1 &&
                                         ((cr_out ^ $past(cr_in)) & ~$past(bit_wmask)) == '0));
endmodule

// File: tb/cr_lut_unit_tb_top.sv
module cr_lut_unit_tb_top;
  localparam real HALF = 2.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_sel = '0;
  logic [31:0] cr_in = '0;
  logic [4:0]  dst_sel = '0, srca_sel = '0, srcb_sel = '0;
  logic [7:0]  imm_tbl = '0;
  logic [3:0]  wr_mask = '0;
  logic        res_valid, illegal;
  logic [31:0] cr_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(HALF) clk = ~clk;

  cr_lut_unit dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel), .cr_in(cr_in),
    .dst_sel(dst_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel), .imm_tbl(imm_tbl),
    .wr_mask(wr_mask), .res_valid(res_valid), .cr_out(cr_out), .illegal(illegal)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  d;
    logic [4:0]  a;
    logic [4:0]  b;
    logic [7:0]  imm;
    logic [3:0]  msk;
    logic [31:0] cr;
    logic [31:0] exp_cr;
    logic        exp_ill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 5'd0,  5'd1, 5'd2,  8'hF0, 4'hF,    32'hA000_0000, 32'h5000_0000, 1'b0}, // R4 not-D
    '{2'd0, 5'd0,  5'd1, 5'd2,  8'hCC, 4'b1100, 32'h0300_0000, 32'hC300_0000, 1'b0}, // R4 R5 not-A, partial mask
    '{2'd1, 5'd2,  5'd3, 5'd4,  8'h00, 4'hF,    32'h00CA_6000, 32'h006A_6000, 1'b0}, // R6 xor table
    '{2'd1, 5'd2,  5'd3, 5'd4,  8'h00, 4'h0,    32'h00CA_6000, 32'h00CA_6000, 1'b1}, // R7 refused
    '{2'd2, 5'd5,  5'd9, 5'd31, 8'h80, 4'h0,    32'h0440_0001, 32'h0040_0001, 1'b0}, // R8 R3 nor clears
    '{2'd2, 5'd5,  5'd9, 5'd31, 8'h80, 4'h0,    32'h0000_0000, 32'h0400_0000, 1'b0}, // R8 nor sets
    '{2'd3, 5'd0,  5'd1, 5'd7,  8'h00, 4'hF,    32'h8000_0008, 32'h0000_0008, 1'b0}, // R9 table field 7
    '{2'd3, 5'd1,  5'd0, 5'd7,  8'h00, 4'h0,    32'h8000_0004, 32'hC000_0004, 1'b0}, // R9 empty mask no trap
    '{2'd0, 5'd3,  5'd1, 5'd2,  8'hFF, 4'h0,    32'h1234_5678, 32'h1234_5678, 1'b0}, // R7 ternary empty mask
    '{2'd0, 5'd7,  5'd0, 5'd0,  8'hFF, 4'b0001, 32'h0000_0000, 32'h0000_0001, 1'b0}, // R5 last bit of last field
    '{2'd1, 5'd7,  5'd7, 5'd0,  8'h00, 4'b0110, 32'h8000_0005, 32'h8000_0003, 1'b0}  // R6 dst==A
  };

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference written over MSB-numbered bit arrays.
  function automatic logic [32:0] model(vec_t v);
    logic m [32];
    logic r [32];
    logic [31:0] res;
    int fd, fa, fb, idx;
    for (int n = 0; n < 32; n++) begin m[n] = v.cr[31-n]; r[n] = m[n]; end
    fd = int'(v.d[2:0]); fa = int'(v.a[2:0]); fb = int'(v.b[2:0]);
    if (v.op == 2'd1 && v.msk == 4'd0) return {1'b1, v.cr};
    case (v.op)
      2'd0, 2'd1: for (int i = 0; i < 4; i++) begin
        if (v.op == 2'd0) idx = 4*int'(m[4*fd+i]) + 2*int'(m[4*fa+i]) + int'(m[4*fb+i]);
        else              idx = 2*int'(m[4*fd+i]) + int'(m[4*fa+i]);
        if (v.msk[3-i]) r[4*fd+i] = (v.op == 2'd0) ? v.imm[7-idx] : m[4*fb+idx];
      end
      2'd2: begin
        idx = 4*int'(m[v.d]) + 2*int'(m[v.a]) + int'(m[v.b]);
        r[v.d] = v.imm[7-idx];
      end
      default: begin
        idx = 2*int'(m[v.d]) + int'(m[v.a]);
        r[v.d] = m[4*fb+idx];
      end
    endcase
    for (int n = 0; n < 32; n++) res[31-n] = r[n];
    return {1'b0, res};
  endfunction

  // Called at a falling edge; returns at the falling edge where the result is visible.
  task automatic run(input vec_t v);
    op_valid = 1'b1; op_sel = v.op; cr_in = v.cr; dst_sel = v.d; srca_sel = v.a;
    srcb_sel = v.b; imm_tbl = v.imm; wr_mask = v.msk;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [32:0] m;
    logic [31:0] held;
    vec_t v;
    seed = 32'h1F2E_3D4C;
    op_valid = 1'b1;               // request during reset must be ignored
    repeat (3) @(negedge clk);
    chk("R1 cr_out", cr_out, 32'h0);
    chk("R1 res_valid", {31'b0, res_valid}, 32'h0);
    chk("R1 illegal", {31'b0, illegal}, 32'h0);
    op_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first cycle valid", {31'b0, res_valid}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      run(VEC[k]);
      chk($sformatf("R2 vec %0d valid", k), {31'b0, res_valid}, 32'h1);
      chk($sformatf("R4-R9 vec %0d cr", k), cr_out, VEC[k].exp_cr);
      chk($sformatf("R7 vec %0d illegal", k), {31'b0, illegal}, {31'b0, VEC[k].exp_ill});
    end

    // R2: idle cycles hold the output and keep res_valid low
    held = cr_out;
    cr_in = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R2 idle hold", cr_out, held);
    chk("R2 idle valid", {31'b0, res_valid}, 32'h0);

    // R10 R3: sweep with a reference model
    for (int k = 0; k < 200; k++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      v.op = seed[31:30]; v.d = seed[29:25]; v.a = seed[24:20]; v.b = seed[19:15];
      v.imm = seed[14:7]; v.msk = seed[6:3];
      seed = seed * 32'd1664525 + 32'd1013904223;
      v.cr = seed ^ {seed[15:0], seed[31:16]};
      v.exp_cr = '0; v.exp_ill = 1'b0;
      m = model(v);
      run(v);
      chk($sformatf("R10 sweep %0d op %0d cr", k, v.op), cr_out, m[31:0]);
      chk($sformatf("R7 sweep %0d illegal", k), {31'b0, illegal}, {31'b0, m[32]});
    end

    done = 1;
    summary();
    $finish;
  end
endmodule